// File: doc/BRIEF.md
# IrDA SIR line interface controller

This block sits between a UART serializer and either an infrared transceiver or an RS485 line driver. On the transmit side it takes the UART's NRZ serial bit and encodes it as IrDA SIR pulses. A zero bit gives one short active-high pulse that starts in the middle of the bit cell. A one bit gives no pulse. On the receive side it turns pulses from the transceiver back into NRZ bits for the UART. Both pins have optional polarity inversion.

The link direction is tracked by a small state machine driven by the UART's `tx_busy` flag. In half-duplex mode the machine can hold transmission off, or keep reception blocked, for a number of character times after the direction turns around. In full-duplex mode, which is used for loopback, both paths stay open and the guard enables have no effect. When RS485 mode is on, `rts_n` is pulled low automatically while a granted transmission is in progress. In RS232 mode `rts_n` simply follows the UART's own request line.

A single configuration byte is loaded through `cfg_wr`/`cfg_wdata`. Timing comes from three strobes supplied by the UART's baud logic: `os_tick` (16 per bit), `bit_tick` (start of each bit cell, coincident with an `os_tick`) and `char_tick` (one per character time). Direction states are `DIR_RX` (receive open), `DIR_TX_HOLD` (transmit requested, guard running), `DIR_TX` (transmit open) and `DIR_RX_HOLD` (transmit ended, guard running). The transitions are:
- **start**: `DIR_RX`/`DIR_RX_HOLD` to `DIR_TX` or `DIR_TX_HOLD` when `tx_busy` rises.
- **release**: `DIR_TX_HOLD` to `DIR_TX` on the last guard `char_tick`.
- **abandon**: `DIR_TX_HOLD` to `DIR_RX` when `tx_busy` drops.
- **finish**: `DIR_TX` to `DIR_RX` or `DIR_RX_HOLD` when `tx_busy` drops.
- **settle**: `DIR_RX_HOLD` to `DIR_RX` on the last guard `char_tick`.

The encoder has two states. `ENC_IDLE` goes to `ENC_PULSE` at mid-cell for a zero bit. `ENC_PULSE` goes back to `ENC_IDLE` when the width count ends or the path is closed.

Top module: `irda_sir_ctrl`

## Requirements
- R1: The configuration byte is loaded on a clock edge with `cfg_wr` high, with these fields: [1:0] mode, [2] half-duplex, [3] TX invert, [4] RX invert, [5] transmit guard, [6] receive guard, [7] RS485. After reset the byte is 0x04, so the link is half duplex with no guards, and a rising `tx_busy` opens transmit (`tx_grant`=1) after one edge.
- R2: With mode 00 or 01 (IR off), `ir_tx` stays at the inactive level (equal to the TX invert bit) and `rx_bit` reads 1.
- R3: In modes 10 and 11 with transmit open, a zero data bit produces exactly one active pulse, which starts on the output after the 8th clock edge following the edge that samples `bit_tick`. A one bit produces no pulse.
- R4: In mode 11 the pulse lasts 3 `os_tick` periods.
- R5: In mode 10 the pulse lasts `FIXED_PULSE_CYC` clock cycles, whatever `os_tick` does.
- R6: When TX invert is set, `ir_tx` is the complement of the uninverted output, including at idle.
- R7: A bit cell in which the receive input is active at any time is reported as `rx_bit`=0 from the `bit_tick` edge that ends the cell. A cell with no pulse is reported as 1.
- R8: When RX invert is set, a low level on `ir_rx` counts as active.
- R9: In half duplex with the transmit guard set, `tx_grant` stays 0 and no pulse is sent until the 4th `char_tick` after `tx_busy` rises.
- R10: In half duplex with the receive guard set, `rx_bit` stays 1 until the 4th `char_tick` after `tx_busy` falls. After that, reception works again.
- R11: In half duplex, reception is blocked while transmit is open. With the half-duplex bit at 0, both paths are open at all times and the guard bits are ignored.
- R12: With RS485 set, `rts_n` is 0 exactly while `tx_busy` is high and transmit is granted, and 1 otherwise. With RS485 clear, `rts_n` equals `uart_rts_n`.
- R13: A direction change restarts the guard count. If `tx_busy` rises in the same cycle as the final receive-guard `char_tick`, the transmit guard still needs 4 further `char_tick`s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Load the configuration byte |
| cfg_wdata | input | 8 | Configuration byte (fields in R1) |
| os_tick | input | 1 | Oversample strobe, 16 per bit |
| bit_tick | input | 1 | Bit-cell start strobe |
| char_tick | input | 1 | Character-time strobe |
| uart_txd | input | 1 | Serial bit from the UART |
| tx_busy | input | 1 | UART is transmitting |
| uart_rts_n | input | 1 | UART request line, passed through in RS232 mode |
| ir_rx | input | 1 | Receive pin from the transceiver |
| ir_tx | output | 1 | Transmit pin to the transceiver |
| rx_bit | output | 1 | Recovered NRZ bit to the UART |
| tx_grant | output | 1 | Transmit path open |
| rts_n | output | 1 | Direction control, active low |

## Verification
The critical coincidence is the direction machine seeing a guard expiry and a direction change in the same cycle. The bench provokes this by raising `tx_busy` on exactly the cycle that carries the fourth receive-guard `char_tick`. It then requires that the direction change wins: `tx_grant` must stay low through three further character strobes and rise only on the fourth. A second overlap is a received pulse that ends close to a `bit_tick`. This is judged by checking that the decoded bit appears at the boundary edge and that the next cell starts clean.

// File: rtl/irda_pkg.sv
package irda_pkg;

    typedef enum logic [1:0] {
        IRM_OFF_A = 2'b00,
        IRM_OFF_B = 2'b01,
        IRM_FIXED = 2'b10,
        IRM_FRAC  = 2'b11
    } ir_mode_e;

    typedef struct packed {
        logic     rs485;
        logic     rx_guard;
        logic     tx_guard;
        logic     rx_inv;
        logic     tx_inv;
        logic     half;
        ir_mode_e mode;
    } sir_cfg_t;

    localparam logic [7:0] CFG_RESET = 8'h04;

    typedef enum logic [1:0] {
        DIR_RX      = 2'd0,
        DIR_TX_HOLD = 2'd1,
        DIR_TX      = 2'd2,
        DIR_RX_HOLD = 2'd3
    } dir_state_e;

    typedef enum logic {
        ENC_IDLE  = 1'b0,
        ENC_PULSE = 1'b1
    } enc_state_e;

endpackage

// File: rtl/irda_dir_guard.sv
module irda_dir_guard
    import irda_pkg::*;
#(
    parameter int GUARD_CHARS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic half,
    input  logic tx_guard,
    input  logic rx_guard,
    input  logic tx_busy,
    input  logic char_tick,
    output logic tx_open,
    output logic rx_open
);
    localparam int GW = $clog2(GUARD_CHARS) + 1;
    localparam logic [GW-1:0] LAST = GW'(GUARD_CHARS - 1);

    dir_state_e st, st_nxt;
    logic [GW-1:0] cnt, cnt_nxt;
    logic tg, rg, expire;

    assign tg = half & tx_guard;
    assign rg = half & rx_guard;
    assign expire = char_tick && (cnt == LAST);

    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt;
        unique case (st)
            DIR_RX: begin
                if (tx_busy) begin
                    st_nxt  = tg ? DIR_TX_HOLD : DIR_TX;
                    cnt_nxt = '0;
                end
            end
            DIR_TX_HOLD: begin
                if (!tx_busy) begin
                    st_nxt  = DIR_RX;
                    cnt_nxt = '0;
                end else if (expire) begin
                    st_nxt  = DIR_TX;
                    cnt_nxt = '0;
                end else if (char_tick) begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            DIR_TX: begin
                if (!tx_busy) begin
                    st_nxt  = rg ? DIR_RX_HOLD : DIR_RX;
                    cnt_nxt = '0;
                end
            end
            DIR_RX_HOLD: begin
                if (tx_busy) begin
                    st_nxt  = tg ? DIR_TX_HOLD : DIR_TX;
                    cnt_nxt = '0;
                end else if (expire) begin
                    st_nxt  = DIR_RX;
                    cnt_nxt = '0;
                end else if (char_tick) begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= DIR_RX;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
        end
    end

    always_comb begin
        tx_open = !half || (st == DIR_TX);
        rx_open = !half || (st == DIR_RX);
    end

    AST_DIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        half |-> !(tx_open && rx_open)); // R11
    AST_GUARD_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R9
endmodule

// File: rtl/irda_pulse_enc.sv
module irda_pulse_enc
    import irda_pkg::*;
#(
    parameter int OS_PER_BIT      = 16,
    parameter int SHORT_OS        = 3,
    parameter int FIXED_PULSE_CYC = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic os_tick,
    input  logic bit_tick,
    input  logic txd,
    input  logic enable,
    input  logic short_mode,
    output logic pulse
);
    localparam int PH_W  = $clog2(OS_PER_BIT);
    localparam int MAXW  = (FIXED_PULSE_CYC > SHORT_OS) ? FIXED_PULSE_CYC : SHORT_OS;
    localparam int CW    = $clog2(MAXW + 1);
    localparam logic [PH_W-1:0] MID = PH_W'(OS_PER_BIT / 2 - 1);

    enc_state_e st, st_nxt;
    logic [PH_W-1:0] ph;
    logic [CW-1:0]   cnt, cnt_nxt;
    logic            bit_q, step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph    <= '0;
            bit_q <= 1'b1;
        end else if (bit_tick) begin
            ph    <= '0;
            bit_q <= txd;
        end else if (os_tick) begin
            ph    <= ph + 1'b1;
        end
    end

    assign step = short_mode ? os_tick : 1'b1;

    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt;
        unique case (st)
            ENC_IDLE: begin
                if (enable && os_tick && !bit_tick && ph == MID && !bit_q) begin
                    st_nxt  = ENC_PULSE;
                    cnt_nxt = short_mode ? CW'(SHORT_OS) : CW'(FIXED_PULSE_CYC);
                end
            end
            ENC_PULSE: begin
                if (!enable) begin
                    st_nxt = ENC_IDLE;
                end else if (step) begin
                    if (cnt == CW'(1)) st_nxt = ENC_IDLE;
                    else               cnt_nxt = cnt - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ENC_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
        end
    end

    always_comb pulse = (st == ENC_PULSE);

    AST_PULSE_MIDCELL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |-> ($past(ph) == MID)); // R3
endmodule

// File: rtl/irda_pulse_dec.sv
module irda_pulse_dec #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic rx_in,
    input  logic enable,
    output logic rx_bit
);
    logic [SYNC_STAGES-1:0] sync;
    logic seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync   <= '0;
            seen   <= 1'b0;
            rx_bit <= 1'b1;
        end else begin
            sync <= {sync[SYNC_STAGES-2:0], rx_in};
            if (!enable) begin
                seen   <= 1'b0;
                rx_bit <= 1'b1;
            end else if (bit_tick) begin
                rx_bit <= ~(seen | sync[SYNC_STAGES-1]);
                seen   <= 1'b0;
            end else if (sync[SYNC_STAGES-1]) begin
                seen <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/irda_sir_ctrl.sv
module irda_sir_ctrl
    import irda_pkg::*;
#(
    parameter int OS_PER_BIT      = 16,
    parameter int SHORT_OS        = 3,
    parameter int FIXED_PULSE_CYC = 32,
    parameter int GUARD_CHARS     = 4,
    parameter int SYNC_STAGES     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_wdata,
    input  logic       os_tick,
    input  logic       bit_tick,
    input  logic       char_tick,
    input  logic       uart_txd,
    input  logic       tx_busy,
    input  logic       uart_rts_n,
    input  logic       ir_rx,
    output logic       ir_tx,
    output logic       rx_bit,
    output logic       tx_grant,
    output logic       rts_n
);
    sir_cfg_t cfg_q;
    logic tx_open, rx_open, ir_on, enc_pulse;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= sir_cfg_t'(CFG_RESET);
        else if (cfg_wr) cfg_q <= sir_cfg_t'(cfg_wdata);
    end

    assign ir_on = cfg_q.mode[1];

    irda_dir_guard #(.GUARD_CHARS(GUARD_CHARS)) u_guard (
        .clk(clk), .rst_n(rst_n), .half(cfg_q.half),
        .tx_guard(cfg_q.tx_guard), .rx_guard(cfg_q.rx_guard),
        .tx_busy(tx_busy), .char_tick(char_tick),
        .tx_open(tx_open), .rx_open(rx_open)
    );

    irda_pulse_enc #(
        .OS_PER_BIT(OS_PER_BIT), .SHORT_OS(SHORT_OS),
        .FIXED_PULSE_CYC(FIXED_PULSE_CYC)
    ) u_enc (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .bit_tick(bit_tick),
        .txd(uart_txd), .enable(tx_open & ir_on),
        .short_mode(cfg_q.mode == IRM_FRAC), .pulse(enc_pulse)
    );

    irda_pulse_dec #(.SYNC_STAGES(SYNC_STAGES)) u_dec (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
        .rx_in(ir_rx ^ cfg_q.rx_inv), .enable(rx_open & ir_on),
        .rx_bit(rx_bit)
    );

    assign ir_tx    = enc_pulse ^ cfg_q.tx_inv;
    assign tx_grant = tx_open;
    assign rts_n    = cfg_q.rs485 ? ~(tx_busy & tx_open) : uart_rts_n;

    AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_open |=> !enc_pulse); // R9
    AST_RX_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_open |=> rx_bit); // R10
    AST_RTS_ONLY_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.rs485 && !rts_n) |-> (tx_busy && tx_open)); // R12
endmodule

// File: tb/sim_irda_sir_ctrl.sv
`timescale 1ns/1ps
module sim_irda_sir_ctrl;
    localparam int FIXW = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic os_tick = 1'b1, bit_tick = 1'b0, char_tick = 1'b0;
    logic uart_txd = 1'b1, tx_busy = 1'b0, uart_rts_n = 1'b1, ir_rx = 1'b0;
    logic ir_tx, rx_bit, tx_grant, rts_n;
    int div = 15;
    int checks = 0, failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irda_sir_ctrl #(.FIXED_PULSE_CYC(FIXW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .os_tick(os_tick), .bit_tick(bit_tick), .char_tick(char_tick),
        .uart_txd(uart_txd), .tx_busy(tx_busy), .uart_rts_n(uart_rts_n),
        .ir_rx(ir_rx), .ir_tx(ir_tx), .rx_bit(rx_bit),
        .tx_grant(tx_grant), .rts_n(rts_n)
    );

    // bit-cell timing: 16 clocks per bit, os_tick every clock
    initial forever begin
        @(negedge clk);
        div = (div == 15) ? 0 : div + 1;
        bit_tick = (div == 0);
    end

    // {mode[1:0], tx_inv, txd, first[4:0], count[2:0]}
    localparam logic [11:0] VEC [8] = '{
        {2'b11, 1'b0, 1'b0, 5'd8, 3'd3},
        {2'b11, 1'b0, 1'b1, 5'd0, 3'd0},
        {2'b10, 1'b0, 1'b0, 5'd8, 3'd5},
        {2'b10, 1'b1, 1'b0, 5'd8, 3'd5},
        {2'b11, 1'b1, 1'b1, 5'd0, 3'd0},
        {2'b00, 1'b0, 1'b0, 5'd0, 3'd0},
        {2'b01, 1'b1, 1'b0, 5'd0, 3'd0},
        {2'b11, 1'b1, 1'b0, 5'd8, 3'd3}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wait_div(input int d);
        do step(); while (div != d);
    endtask

    task automatic write_cfg(input logic [7:0] v);
        step(); cfg_wr = 1'b1; cfg_wdata = v;
        step(); cfg_wr = 1'b0;
    endtask

    task automatic char_pulse(input int n);
        for (int i = 0; i < n; i++) begin
            step(); char_tick = 1'b1;
            step(); char_tick = 1'b0;
        end
    endtask

    task automatic run_cell(input logic b, input logic inv, output int first, output int cnt);
        wait_div(8);
        uart_txd = b;
        wait_div(0);
        first = 0; cnt = 0;
        for (int k = 1; k <= 16; k++) begin
            step();
            if ((ir_tx ^ inv) == 1'b1) begin
                if (cnt == 0) first = k;
                cnt++;
            end
        end
    endtask

    // drive one received cell and return the decoded bit at the closing edge
    task automatic rx_cell(input logic pulse, input logic inv, output logic got);
        ir_rx = inv;
        wait_div(0);
        wait_div(6);
        if (pulse) ir_rx = ~inv;
        step(); step(); step();
        ir_rx = inv;
        wait_div(0);
        got = rx_bit;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int f, c;
        logic g;
        repeat (5) step();
        rst_n = 1'b1;
        step();
        // reset state
        chk("R2", ir_tx, 0);
        chk("R2", rx_bit, 1);
        chk("R1", tx_grant, 0);
        uart_rts_n = 1'b0; #0.5;
        chk("R12", rts_n, 0);
        uart_rts_n = 1'b1;
        tx_busy = 1'b1;
        step();
        chk("R1", tx_grant, 1);

        // table walk: encoder shapes, widths, inversion, disabled modes
        foreach (VEC[i]) begin
            logic [11:0] v;
            v = VEC[i];
            write_cfg({3'b000, 1'b0, v[9], 1'b1, v[11:10]});
            run_cell(v[8], v[9], f, c);
            chk("R3", f, int'(v[7:3]));
            if (v[11:10] == 2'b11)      chk("R4", c, int'(v[2:0]));
            else if (v[11:10] == 2'b10) chk("R5", c, int'(v[2:0]));
            else                        chk("R2", c, int'(v[2:0]));
            chk("R6", ir_tx, v[9]);
        end

        // decoder, with and without inversion
        tx_busy = 1'b0;
        write_cfg(8'h07);
        rx_cell(1'b1, 1'b0, g); chk("R7", g, 0);
        rx_cell(1'b0, 1'b0, g); chk("R7", g, 1);
        write_cfg(8'h17);
        rx_cell(1'b1, 1'b1, g); chk("R8", g, 0);
        rx_cell(1'b0, 1'b1, g); chk("R8", g, 1);
        write_cfg(8'h04);
        rx_cell(1'b1, 1'b0, g); chk("R2", g, 1);

        // half duplex blocks reception while sending; full duplex ignores guards
        write_cfg(8'h07);
        tx_busy = 1'b1;
        rx_cell(1'b1, 1'b0, g); chk("R11", g, 1);
        write_cfg(8'h63);
        chk("R11", tx_grant, 1);
        rx_cell(1'b1, 1'b0, g); chk("R11", g, 0);
        tx_busy = 1'b0;
        step();
        chk("R11", tx_grant, 1);

        // transmit guard
        write_cfg(8'h27);
        step(); step();
        tx_busy = 1'b1;
        step();
        chk("R9", tx_grant, 0);
        char_pulse(3);
        chk("R9", tx_grant, 0);
        run_cell(1'b0, 1'b0, f, c);
        chk("R9", c, 0);
        char_pulse(1);
        chk("R9", tx_grant, 1);
        run_cell(1'b0, 1'b0, f, c);
        chk("R9", c, 3);

        // RS485 and RS232 direction control
        write_cfg(8'h87);
        chk("R12", rts_n, 0);
        tx_busy = 1'b0;
        step();
        chk("R12", rts_n, 1);
        write_cfg(8'hA7);
        tx_busy = 1'b1;
        step();
        chk("R12", rts_n, 1);
        char_pulse(4);
        chk("R12", rts_n, 0);
        write_cfg(8'h07);
        uart_rts_n = 1'b0; step();
        chk("R12", rts_n, 0);
        uart_rts_n = 1'b1; step();
        chk("R12", rts_n, 1);

        // receive guard
        write_cfg(8'h47);
        step();
        tx_busy = 1'b0;
        step();
        rx_cell(1'b1, 1'b0, g); chk("R10", g, 1);
        char_pulse(4);
        rx_cell(1'b1, 1'b0, g); chk("R10", g, 0);

        // guard restart on direction change coinciding with guard expiry
        write_cfg(8'h67);
        tx_busy = 1'b1;
        step();
        char_pulse(4);
        chk("R13", tx_grant, 1);
        tx_busy = 1'b0;
        step();
        char_pulse(3);
        step(); char_tick = 1'b1; tx_busy = 1'b1;
        step(); char_tick = 1'b0;
        chk("R13", tx_grant, 0);
        char_pulse(3);
        chk("R13", tx_grant, 0);
        char_pulse(1);
        chk("R13", tx_grant, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule